// File: doc/BRIEF.md
# Fractional Multiply Execution Unit

This unit executes the fractional (Q-format) multiply instructions of a small 8-bit microcontroller datapath. Each cycle it looks at the presented 16-bit instruction word and decodes it. It sends two register numbers to the register file's read ports and receives two bytes back. When the word is one of the three fractional multiply variants, it forms the 16-bit product and doubles it with a one-bit left shift. On the next clock edge it writes the product to the fixed register pair R1:R0 and updates the carry and zero flags.

Only the eight registers 16 to 23 can be operands, because each operand field is three bits wide and is offset by 16. Carry is the top bit of the product before the shift, which is the bit that the shift drops. Zero describes the shifted value that is written. A feature-enable input turns the whole instruction group into a no-operation. The register file and all other instructions lie outside the unit.

Top module: `qmul_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, res_we is 0, and res_lo, res_hi, flag_c and flag_z are all 0.
- R2: rd_a_idx always equals 16 + instr[6:4] and rd_b_idx always equals 16 + instr[2:0], as 5-bit register numbers, whatever the rest of the word holds.
- R3: A word is a fractional multiply only when instr[15:8] = 8'h03 and at least one of instr[7] and instr[3] is 1. Every other word, including 8'h03 with instr[7] = 0 and instr[3] = 0, gives res_we = 0 and leaves the result and flag outputs unchanged.
- R4: For instr[7] = 0 and instr[3] = 1, both operands are treated as unsigned.
- R5: For instr[7] = 1 and instr[3] = 0, both operands are treated as two's-complement signed.
- R6: For instr[7] = 1 and instr[3] = 1, the first operand (rd_a_data) is signed and the second (rd_b_data) is unsigned. The product is truncated to 16 bits.
- R7: flag_c takes bit 15 of the 16-bit product before the shift.
- R8: The written value is the 16-bit product shifted left by one with a 0 shifted in. res_lo holds bits 7:0 of that value and res_hi holds bits 15:8.
- R9: flag_z is 1 exactly when the shifted 16-bit value is zero.
- R10: While mul_en is 0, no instruction asserts res_we or changes any result or flag output.
- R11: An accepted instruction (instr_valid = 1, mul_en = 1, a legal encoding) updates res_lo, res_hi, flag_c and flag_z together on the next clock edge, and res_we is 1 for exactly that cycle. With no accepted instruction these outputs hold their values and res_we is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 16 | Instruction word |
| mul_en | input | 1 | Multiply feature enable |
| rd_a_idx | output | 5 | Register number for the first operand read |
| rd_b_idx | output | 5 | Register number for the second operand read |
| rd_a_data | input | 8 | First operand byte returned by the register file |
| rd_b_data | input | 8 | Second operand byte returned by the register file |
| res_we | output | 1 | Write strobe for the result pair |
| res_lo | output | 8 | Low result byte, destined for R0 |
| res_hi | output | 8 | High result byte, destined for R1 |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the unit with its default parameters: 8-bit operands, a register base of 16 and 5-bit register numbers. With these values the full operand range fits in a short run, so it can cover the extremes: -128 times -128 in the signed variant, 255 times 255 with a carry-out, and a signed -1 against an unsigned 255. Registers outside 16 to 23 hold a marker value, so an index mapping error shows up as a wrong product. Illegal words, a disabled feature and idle cycles are mixed between accepted instructions, which shows whether the held outputs stay put.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  typedef enum logic [1:0] {
    QM_NONE = 2'd0,
    QM_UU   = 2'd1,
    QM_SS   = 2'd2,
    QM_SU   = 2'd3
  } qm_kind_e;

  localparam int INSTR_W   = 16;
  localparam int OPC_LSB   = 8;
  localparam int OPC_W     = 8;
  localparam int SEL_HI    = 7;
  localparam int SEL_LO    = 3;
  localparam int FLD_A_LSB = 4;
  localparam int FLD_B_LSB = 0;
endpackage

// File: rtl/qmul_decode.sv
module qmul_decode
  import qmul_pkg::*;
#(
  parameter int          IDX_W      = 3,
  parameter int          REG_ADDR_W = 5,
  parameter int          REG_BASE   = 16,
  parameter logic [7:0]  OPCODE     = 8'h03
) (
  input  logic [INSTR_W-1:0]    instr,
  output qm_kind_e              kind,
  output logic                  is_fmul,
  output logic [REG_ADDR_W-1:0] idx_a,
  output logic [REG_ADDR_W-1:0] idx_b
);
  localparam logic [REG_ADDR_W-1:0] BASE_V = REG_ADDR_W'(REG_BASE);
  localparam int FLD_LSB [2] = '{FLD_A_LSB, FLD_B_LSB};

  logic [REG_ADDR_W-1:0] idx_arr [2];
  logic                  opc_hit;

  for (genvar g = 0; g < 2; g++) begin : g_fld
    logic [IDX_W-1:0] fld;
    assign fld        = instr[FLD_LSB[g] +: IDX_W];
    assign idx_arr[g] = BASE_V + REG_ADDR_W'(fld);
  end

  assign idx_a   = idx_arr[0];
  assign idx_b   = idx_arr[1];
  assign opc_hit = (instr[OPC_LSB +: OPC_W] == OPCODE);

  always_comb begin
    kind = QM_NONE;
    if (opc_hit) begin
      unique case ({instr[SEL_HI], instr[SEL_LO]})
        2'b01:   kind = QM_UU;
        2'b10:   kind = QM_SS;
        2'b11:   kind = QM_SU;
        default: kind = QM_NONE;
      endcase
    end
  end

  assign is_fmul = (kind != QM_NONE);

  always_comb begin
    assert_decode_opc_R3: assert (!is_fmul || opc_hit);
  end
endmodule

// File: rtl/qmul_core.sv
module qmul_core
  import qmul_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  qm_kind_e            kind,
  output logic [2*DATA_W-1:0] prod_raw,
  output logic [2*DATA_W-1:0] prod_shl,
  output logic                carry,
  output logic                zero
);
  localparam int PW = 2 * DATA_W;

  function automatic logic [PW-1:0] frac_product(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input qm_kind_e          k
  );
    logic signed [DATA_W:0]   ea;
    logic signed [DATA_W:0]   eb;
    logic signed [PW+1:0]     p;
    ea = signed'({(k != QM_UU) & a[DATA_W-1], a});
    eb = signed'({(k == QM_SS) & b[DATA_W-1], b});
    p  = ea * eb;
    return p[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] double_q(input logic [PW-1:0] v);
    return {v[PW-2:0], 1'b0};
  endfunction

  assign prod_raw = frac_product(op_a, op_b, kind);
  assign prod_shl = double_q(prod_raw);
  assign carry    = prod_raw[PW-1];
  assign zero     = (prod_shl == '0);

  always_comb begin
    assert_zero_operand_R4: assert ((op_a != '0 && op_b != '0) || prod_raw == '0);
  end
endmodule

// File: rtl/qmul_wb.sv
module qmul_wb #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [2*DATA_W-1:0] value,
  input  logic                carry,
  input  logic                zero,
  output logic                res_we,
  output logic [DATA_W-1:0]   res_lo,
  output logic [DATA_W-1:0]   res_hi,
  output logic                flag_c,
  output logic                flag_z
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_we <= 1'b0;
      res_lo <= '0;
      res_hi <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      res_we <= commit;
      if (commit) begin
        res_lo <= value[DATA_W-1:0];
        res_hi <= value[2*DATA_W-1:DATA_W];
        flag_c <= carry;
        flag_z <= zero;
      end
    end
  end

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_we |-> ($stable(res_lo) && $stable(res_hi) && $stable(flag_c) && $stable(flag_z)));
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (flag_z == ({res_hi, res_lo} == '0)));
  assert_shift_in_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_lo[0] == 1'b0));
endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
  import qmul_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 3,
  parameter int REG_ADDR_W = 5,
  parameter int REG_BASE   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  instr_valid,
  input  logic [INSTR_W-1:0]    instr,
  input  logic                  mul_en,
  output logic [REG_ADDR_W-1:0] rd_a_idx,
  output logic [REG_ADDR_W-1:0] rd_b_idx,
  input  logic [DATA_W-1:0]     rd_a_data,
  input  logic [DATA_W-1:0]     rd_b_data,
  output logic                  res_we,
  output logic [DATA_W-1:0]     res_lo,
  output logic [DATA_W-1:0]     res_hi,
  output logic                  flag_c,
  output logic                  flag_z
);
  localparam int PW = 2 * DATA_W;

  qm_kind_e       kind;
  logic           is_fmul;
  logic           commit;
  logic [PW-1:0]  prod_raw;
  logic [PW-1:0]  prod_shl;
  logic           carry;
  logic           zero;

  qmul_decode #(
    .IDX_W      (IDX_W),
    .REG_ADDR_W (REG_ADDR_W),
    .REG_BASE   (REG_BASE)
  ) u_decode (
    .instr   (instr),
    .kind    (kind),
    .is_fmul (is_fmul),
    .idx_a   (rd_a_idx),
    .idx_b   (rd_b_idx)
  );

  qmul_core #(.DATA_W(DATA_W)) u_core (
    .op_a     (rd_a_data),
    .op_b     (rd_b_data),
    .kind     (kind),
    .prod_raw (prod_raw),
    .prod_shl (prod_shl),
    .carry    (carry),
    .zero     (zero)
  );

  assign commit = instr_valid && mul_en && is_fmul;

  qmul_wb #(.DATA_W(DATA_W)) u_wb (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .value  (prod_shl),
    .carry  (carry),
    .zero   (zero),
    .res_we (res_we),
    .res_lo (res_lo),
    .res_hi (res_hi),
    .flag_c (flag_c),
    .flag_z (flag_z)
  );

  assert_we_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> $past(mul_en && instr_valid));
  assert_illegal_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !is_fmul) |=> !res_we);
  assert_carry_from_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (flag_c == $past(prod_raw[PW-1])));
endmodule

// File: tb/qmul_unit_tb.sv
`timescale 1ns/1ps
module qmul_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        mul_en = 1'b0;
  logic [4:0]  rd_a_idx, rd_b_idx;
  logic [7:0]  rd_a_data, rd_b_data;
  logic        res_we;
  logic [7:0]  res_lo, res_hi;
  logic        flag_c, flag_z;

  logic [7:0]  rf [32];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  logic        e_we = 0;
  logic [7:0]  e_lo = 0, e_hi = 0;
  logic        e_c = 0, e_z = 0;

  always #4 clk = ~clk;

  assign rd_a_data = rf[rd_a_idx];
  assign rd_b_data = rf[rd_b_idx];

  qmul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .mul_en(mul_en), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .res_we(res_we),
    .res_lo(res_lo), .res_hi(res_hi), .flag_c(flag_c), .flag_z(flag_z)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check(tag, {13'd0, res_we, res_hi, res_lo, flag_c, flag_z},
               {13'd0, e_we, e_hi, e_lo, e_c, e_z});
  endtask

  // Behavioural model of one accepted or rejected cycle
  task automatic model(input logic [15:0] ins, input logic v, input logic en);
    int a, b, p, s;
    logic sa, sb, legal;
    legal = (ins[15:8] == 8'h03) && (ins[7] || ins[3]);
    e_we  = v && en && legal;
    if (e_we) begin
      sa = ins[7];
      sb = ins[7] && !ins[3];
      a  = rf[16 + ins[6:4]];
      b  = rf[16 + ins[2:0]];
      if (sa && a > 127) a = a - 256;
      if (sb && b > 127) b = b - 256;
      p  = (a * b) & 32'hFFFF;
      s  = (p * 2) & 32'hFFFF;
      e_c  = p[15];
      e_lo = s[7:0];
      e_hi = s[15:8];
      e_z  = (s == 0);
    end
  endtask

  task automatic step(input logic [15:0] ins, input logic v, input logic en, input string tag);
    instr = ins; instr_valid = v; mul_en = en;
    #1;
    check("R2 idx_a", {27'd0, rd_a_idx}, 32'(16 + ins[6:4]));
    check("R2 idx_b", {27'd0, rd_b_idx}, 32'(16 + ins[2:0]));
    model(ins, v, en);
    @(negedge clk);
    check_outs(tag);
  endtask

  function automatic logic [15:0] mk(input logic b7, input logic b3, input int ra, input int rb);
    return {8'h03, b7, 3'(ra), b3, 3'(rb)};
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 8'hA5;
    rf[16] = 8'hFF; rf[17] = 8'hFF; rf[18] = 8'h80; rf[19] = 8'h80;
    rf[20] = 8'h00; rf[21] = 8'h40; rf[22] = 8'h01; rf[23] = 8'h7F;
    repeat (2) @(negedge clk);
    check_outs("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 after reset");

    step(mk(0, 1, 0, 1), 1, 1, "R4 R7 uu 255*255");
    check("R7 carry set", {31'd0, flag_c}, 32'd1);
    check("R8 value", {16'd0, res_hi, res_lo}, 32'h0000FC02);
    step(mk(1, 0, 2, 3), 1, 1, "R5 ss -128*-128");
    check("R5 value", {16'd0, res_hi, res_lo}, 32'h00008000);
    step(mk(1, 1, 0, 1), 1, 1, "R6 su -1*255");
    check("R6 value", {16'd0, res_hi, res_lo}, 32'h0000FE02);
    step(mk(1, 0, 0, 7), 1, 1, "R5 ss -1*127");
    step(mk(0, 1, 4, 5), 1, 1, "R9 zero operand");
    check("R9 zero flag", {31'd0, flag_z}, 32'd1);
    step(mk(1, 1, 5, 6), 1, 1, "R6 su 64*1");
    step(mk(0, 1, 0, 1), 1, 0, "R10 disabled");
    step(mk(1, 0, 2, 3), 1, 0, "R10 disabled ss");
    step(16'h0312, 1, 1, "R3 bits7,3 clear");
    step(16'h0B89, 1, 1, "R3 wrong opcode");
    step(mk(1, 1, 0, 1), 0, 1, "R11 not valid");
    step(mk(0, 1, 7, 7), 1, 1, "R11 back to back a");
    step(mk(1, 0, 7, 3), 1, 1, "R11 back to back b");
    step(mk(0, 1, 7, 7), 0, 0, "R11 idle hold");

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      for (int r = 16; r < 24; r++) if ($urandom_range(0, 3) == 0) rf[r] = 8'($urandom);
      w = 16'($urandom);
      if ($urandom_range(0, 7) != 0) w[15:8] = 8'h03;
      step(w, ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0),
           "R4 R5 R6 R7 R8 R9 R3 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule